// File: doc/BRIEF.md
# CAN Receive Queue with Mailbox Window

This block keeps a short queue of CAN frames that a protocol engine has finished receiving. The engine supplies one decoded frame per cycle: its identifier, the extended-format and remote-request bits, the length code, eight data bytes and a 16-bit capture stamp. The host never reads the queue storage itself. It sees only the oldest stored frame, presented as four 32-bit words at word addresses 0 to 3. A flag register at address 4 and a free-running timer at address 5 complete the register interface.

The host handles one frame at a time. It reads the control word first, which freezes the window. It then reads the remaining words and acknowledges the frame by writing a one to the frame-available flag, which retires that entry. A read of the timer unfreezes the window, and the next frame becomes visible. The flag register also reports a warning when the queue is almost full and a sticky overflow bit for frames that were lost because the queue was full.

Top module: `can_rxq_top`

## Requirements
- R1: After reset the flag register reads 0, all four window words read 0 and the window is not frozen.
- R2: Window word 0 (control) reads {4'b0, code[3:0], 1'b0, SRR, IDE, RTR, len[3:0], stamp[15:0]}. The code is 4'h2 when a frame is shown. SRR equals IDE. When the queue is empty, all four window words read 0.
- R3: Window word 1 (identifier) has bits 31:29 at zero. For a standard frame (IDE=0) it holds frm_id[10:0] in bits 28:18, with bits 17:0 at zero. For an extended frame (IDE=1) it holds frm_id[28:0] in bits 28:0.
- R4: Data byte 0 (frm_data[63:56]) appears in bits 31:24 of word 2, and byte 4 appears in bits 31:24 of word 3. In other words, word 2 is frm_data[63:32] and word 3 is frm_data[31:0].
- R5: Up to DEPTH (6) frames are kept in arrival order. The window shows the oldest one. Writing a one to bit 5 of the flag register (address 4) retires it, and when the window is not frozen the next frame is visible from the next cycle.
- R6: Flag bit 5 (available) reads 1 exactly while the queue holds at least one frame. Writing a one to it while the queue is empty changes nothing.
- R7: Flag bit 6 (warning) reads 1 exactly while WARN_LVL (5) or more entries are occupied. Writes to bit 6 have no effect.
- R8: A frame that arrives while the queue is full, and is not accompanied by a retire in the same cycle, is dropped. The stored entries are unchanged and flag bit 7 (overflow) sets. Bit 7 stays set until a one is written to it. If a new drop and the clear happen in the same cycle, the set wins.
- R9: A read of window word 0 freezes the window, so later retires and arrivals do not change any of the four words. A read of the timer (address 5) unfreezes it.
- R10: Address 5 reads a 16-bit counter in bits 15:0, with bits 31:16 at zero. The counter is cleared by reset and advances by one every cycle.
- R11: An arrival and a retire in the same cycle on a full queue store the new frame and do not set overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | A completed frame is offered this cycle |
| frm_ide | input | 1 | Extended identifier format |
| frm_rtr | input | 1 | Remote request frame |
| frm_len | input | 4 | Length code |
| frm_id | input | 29 | Identifier (standard uses bits 10:0) |
| frm_data | input | 64 | Data bytes, byte 0 in bits 63:56 |
| frm_stamp | input | 16 | Capture stamp |
| bus_sel | input | 1 | Host access this cycle |
| bus_we | input | 1 | Host access is a write |
| bus_addr | input | 3 | Host word address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid in the cycle of the access |

## Verification
The assertions assume that the host performs at most one access per cycle and treats every access as lasting exactly one cycle. This matters because each read of word 0 or of the timer is taken as a lock or unlock event. They also assume that the engine presents each frame for a single cycle. The bench drives each bus access and each frame for exactly one clock, between falling edges. It reaches the full, overflow and simultaneous arrive-and-retire cases only through these single-cycle operations.

// File: rtl/can_rxq_pkg.sv
package can_rxq_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_IDW  = 3'd1;
    localparam logic [ADDR_W-1:0] A_DLO  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DHI  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;
    localparam logic [ADDR_W-1:0] A_TMR  = 3'd5;

    localparam int unsigned BIT_AVAIL = 5;
    localparam int unsigned BIT_WARN  = 6;
    localparam int unsigned BIT_OVF   = 7;

    localparam logic [3:0] CODE_NONE = 4'h0;
    localparam logic [3:0] CODE_FULL = 4'h2;

    typedef struct packed {
        logic        ide;
        logic        rtr;
        logic [3:0]  len;
        logic [28:0] id;
        logic [63:0] data;
        logic [15:0] stamp;
    } rxq_frame_t;

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] idw;
        logic [31:0] dlo;
        logic [31:0] dhi;
    } mbox_t;

    // Format a stored frame into the four host-visible words.
    function automatic mbox_t mbox_pack(input rxq_frame_t f, input logic valid);
        mbox_t m;
        m = '0;
        if (valid) begin
            m.ctl = {4'b0, CODE_FULL, 1'b0, f.ide, f.ide, f.rtr, f.len, f.stamp};
            m.idw = f.ide ? {3'b0, f.id} : {3'b0, f.id[10:0], 18'b0};
            m.dlo = f.data[63:32];
            m.dhi = f.data[31:0];
        end
        return m;
    endfunction

endpackage

// File: rtl/can_rxq_store.sv
module can_rxq_store
    import can_rxq_pkg::*;
#(
    parameter int unsigned DEPTH    = 6,
    parameter int unsigned WARN_LVL = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  rxq_frame_t                 frame_i,
    input  logic                       pop_i,
    output rxq_frame_t                 head_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o,
    output logic                       empty_o,
    output logic                       warn_o,
    output logic                       drop_o
);

    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rxq_frame_t [DEPTH-1:0] mem;
        logic [PW-1:0]          wr;
        logic [PW-1:0]          rd;
        logic [CW-1:0]          cnt;
    } st_t;

    st_t st_d, st_q;

    logic do_pop, do_push, full;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (st_q.cnt == CW'(DEPTH));
        do_pop  = pop_i && (st_q.cnt != '0);
        do_push = push_i && (!full || do_pop);
        drop_o  = push_i && !do_push;

        st_d = st_q;
        if (do_push) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.wr == PW'(i)) begin
                    st_d.mem[i] = frame_i;
                end
            end
            st_d.wr = ptr_next(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = ptr_next(st_q.rd);
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);

        head_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.rd == PW'(i)) begin
                head_o = st_q.mem[i];
            end
        end
        cnt_o   = st_q.cnt;
        empty_o = (st_q.cnt == '0);
        warn_o  = (st_q.cnt >= CW'(WARN_LVL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/can_rxq_window.sv
module can_rxq_window
    import can_rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rxq_frame_t head_i,
    input  logic       empty_i,
    input  logic       rd_ctl_i,
    input  logic       rd_tmr_i,
    output mbox_t      view_o,
    output logic       lock_o
);

    typedef struct packed {
        logic  lock;
        mbox_t snap;
    } st_t;

    st_t   st_d, st_q;
    mbox_t live;

    always_comb begin
        live = mbox_pack(head_i, !empty_i);
        st_d = st_q;
        if (rd_tmr_i) begin
            st_d.lock = 1'b0;
        end else if (rd_ctl_i && !st_q.lock) begin
            st_d.lock = 1'b1;
            st_d.snap = live;
        end
        view_o = st_q.lock ? st_q.snap : live;
        lock_o = st_q.lock;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/can_rxq_regs.sv
module can_rxq_regs
    import can_rxq_pkg::*;
#(
    parameter int unsigned TS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              empty_i,
    input  logic              warn_i,
    input  logic              drop_i,
    input  mbox_t             view_i,
    output logic [31:0]       bus_rdata,
    output logic              pop_o,
    output logic              rd_ctl_o,
    output logic              rd_tmr_o,
    output logic              ovf_o,
    output logic [TS_W-1:0]   tmr_o
);

    typedef struct packed {
        logic            ovf;
        logic [TS_W-1:0] tmr;
    } st_t;

    st_t  st_d, st_q;
    logic wr_flag, rd_any;
    logic unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:8], bus_wdata[BIT_WARN], bus_wdata[4:0]};

    always_comb begin
        wr_flag  = bus_sel && bus_we && (bus_addr == A_FLAG);
        rd_any   = bus_sel && !bus_we;
        pop_o    = wr_flag && bus_wdata[BIT_AVAIL];
        rd_ctl_o = rd_any && (bus_addr == A_CTL);
        rd_tmr_o = rd_any && (bus_addr == A_TMR);

        st_d     = st_q;
        st_d.tmr = st_q.tmr + 1'b1;
        if (drop_i) begin
            st_d.ovf = 1'b1;
        end else if (wr_flag && bus_wdata[BIT_OVF]) begin
            st_d.ovf = 1'b0;
        end

        bus_rdata = '0;
        case (bus_addr)
            A_CTL:  bus_rdata = view_i.ctl;
            A_IDW:  bus_rdata = view_i.idw;
            A_DLO:  bus_rdata = view_i.dlo;
            A_DHI:  bus_rdata = view_i.dhi;
            A_FLAG: begin
                bus_rdata[BIT_AVAIL] = !empty_i;
                bus_rdata[BIT_WARN]  = warn_i;
                bus_rdata[BIT_OVF]   = st_q.ovf;
            end
            A_TMR:  bus_rdata = 32'(st_q.tmr);
            default: bus_rdata = '0;
        endcase

        ovf_o = st_q.ovf;
        tmr_o = st_q.tmr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/can_rxq_top.sv
module can_rxq_top
    import can_rxq_pkg::*;
#(
    parameter int unsigned DEPTH    = 6,
    parameter int unsigned WARN_LVL = 5,
    parameter int unsigned TS_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              frm_ide,
    input  logic              frm_rtr,
    input  logic [3:0]        frm_len,
    input  logic [28:0]       frm_id,
    input  logic [63:0]       frm_data,
    input  logic [15:0]       frm_stamp,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    rxq_frame_t      in_frame, head;
    mbox_t           view;
    logic [CW-1:0]   q_cnt;
    logic            q_empty, q_warn, q_drop;
    logic            pop_req, rd_ctl, rd_tmr, win_lock, ovf_flag;
    logic [TS_W-1:0] tmr_val;

    assign in_frame = '{ide: frm_ide, rtr: frm_rtr, len: frm_len, id: frm_id,
                        data: frm_data, stamp: frm_stamp};

    can_rxq_store #(.DEPTH(DEPTH), .WARN_LVL(WARN_LVL)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (frm_valid),
        .frame_i (in_frame),
        .pop_i   (pop_req),
        .head_o  (head),
        .cnt_o   (q_cnt),
        .empty_o (q_empty),
        .warn_o  (q_warn),
        .drop_o  (q_drop)
    );

    can_rxq_window window_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .head_i   (head),
        .empty_i  (q_empty),
        .rd_ctl_i (rd_ctl),
        .rd_tmr_i (rd_tmr),
        .view_o   (view),
        .lock_o   (win_lock)
    );

    can_rxq_regs #(.TS_W(TS_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .empty_i   (q_empty),
        .warn_i    (q_warn),
        .drop_i    (q_drop),
        .view_i    (view),
        .bus_rdata (bus_rdata),
        .pop_o     (pop_req),
        .rd_ctl_o  (rd_ctl),
        .rd_tmr_o  (rd_tmr),
        .ovf_o     (ovf_flag),
        .tmr_o     (tmr_val)
    );

endmodule

// File: rtl/can_rxq_checker.sv
module can_rxq_checker #(
    parameter int unsigned DEPTH = 6,
    parameter int unsigned TS_W  = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       push,
    input logic                       pop,
    input logic                       drop,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       ovf,
    input logic                       locked,
    input logic                       rd_ctl,
    input logic                       rd_tmr,
    input logic [TS_W-1:0]            tmr
);

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ($clog2(DEPTH+1))'(DEPTH));

    assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count == '0 && !push) |=> (count == '0));

    assert_drop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> (count == ($clog2(DEPTH+1))'(DEPTH)));

    assert_drop_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf);

    assert_full_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && count == ($clog2(DEPTH+1))'(DEPTH)) |-> !drop);

    assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl |=> locked);

    assert_unlock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_tmr |=> !locked);

    assert_timer_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (tmr == TS_W'($past(tmr) + 1'b1)));

endmodule

bind can_rxq_top can_rxq_checker #(.DEPTH(DEPTH), .TS_W(TS_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (frm_valid),
    .pop    (pop_req),
    .drop   (q_drop),
    .count  (q_cnt),
    .ovf    (ovf_flag),
    .locked (win_lock),
    .rd_ctl (rd_ctl),
    .rd_tmr (rd_tmr),
    .tmr    (tmr_val)
);

// File: tb/can_rxq_top_tb_top.sv
module can_rxq_top_tb_top;
    import can_rxq_pkg::*;

    localparam int DEPTH = 6;
    localparam int WARN  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0, frm_ide = 1'b0, frm_rtr = 1'b0;
    logic [3:0]  frm_len = '0;
    logic [28:0] frm_id = '0;
    logic [63:0] frm_data = '0;
    logic [15:0] frm_stamp = '0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    always #5 clk = ~clk;

    can_rxq_top dut_i (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ide(frm_ide),
        .frm_rtr(frm_rtr), .frm_len(frm_len), .frm_id(frm_id), .frm_data(frm_data),
        .frm_stamp(frm_stamp), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic        ide;
        logic        rtr;
        logic [3:0]  len;
        logic [28:0] id;
        logic [63:0] data;
        logic [15:0] stamp;
    } bframe_t;

    bframe_t model_q[$];
    logic    ovf_m = 1'b0;
    int      total = 0;
    int      fails = 0;

    function automatic logic [31:0] exp_ctl(input bframe_t f);
        return {4'b0, 4'h2, 1'b0, f.ide, f.ide, f.rtr, f.len, f.stamp};
    endfunction

    function automatic logic [31:0] exp_idw(input bframe_t f);
        return f.ide ? {3'b0, f.id} : {3'b0, f.id[10:0], 18'b0};
    endfunction

    function automatic bframe_t rand_frame();
        bframe_t f;
        f.ide   = 1'($urandom % 2);
        f.rtr   = 1'($urandom % 2);
        f.len   = 4'($urandom % 9);
        f.id    = 29'($urandom);
        f.data  = {$urandom, $urandom};
        f.stamp = 16'($urandom);
        return f;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic drive_frame(input bframe_t f);
        frm_ide = f.ide; frm_rtr = f.rtr; frm_len = f.len; frm_id = f.id;
        frm_data = f.data; frm_stamp = f.stamp;
    endtask

    task automatic push(input bframe_t f);
        drive_frame(f);
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
        if (model_q.size() < DEPTH) model_q.push_back(f);
        else ovf_m = 1'b1;
    endtask

    task automatic pop();
        wr(A_FLAG, 32'h20);
        if (model_q.size() > 0) void'(model_q.pop_front());
    endtask

    task automatic check_flags(input string req);
        logic [31:0] d;
        logic [31:0] e;
        rd(A_FLAG, d);
        e = '0;
        e[5] = (model_q.size() != 0);
        e[6] = (model_q.size() >= WARN);
        e[7] = ovf_m;
        chk(req, d, e);
    endtask

    task automatic check_window(input string req);
        logic [31:0] d;
        bframe_t     f;
        if (model_q.size() == 0) begin
            rd(A_CTL, d); chk({req, " R2 empty ctl"}, d, 32'h0);
            rd(A_IDW, d); chk({req, " R2 empty id"}, d, 32'h0);
            rd(A_DLO, d); chk({req, " R2 empty dlo"}, d, 32'h0);
            rd(A_DHI, d); chk({req, " R2 empty dhi"}, d, 32'h0);
        end else begin
            f = model_q[0];
            rd(A_CTL, d); chk({req, " R2 ctl"}, d, exp_ctl(f));
            rd(A_IDW, d); chk({req, " R3 id"}, d, exp_idw(f));
            rd(A_DLO, d); chk({req, " R4 dlo"}, d, f.data[63:32]);
            rd(A_DHI, d); chk({req, " R4 dhi"}, d, f.data[31:0]);
        end
        rd(A_TMR, d);
    endtask

    task automatic drain(input string req);
        while (model_q.size() > 0) begin
            check_window(req);
            pop();
        end
        check_window(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d, t0, t1;
        bframe_t     fa, fb;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_flags("R1 flags");
        check_window("R1");

        // R2 R3 R4: standard and extended frames
        fa = '{ide: 1'b0, rtr: 1'b1, len: 4'd3, id: 29'h1ABCD7FF,
               data: 64'h0102030405060708, stamp: 16'hBEEF};
        fb = '{ide: 1'b1, rtr: 1'b0, len: 4'd8, id: 29'h1FFFFFFF,
               data: 64'hA0B1C2D3E4F50617, stamp: 16'h0001};
        push(fa);
        check_flags("R6 avail");
        check_window("R2");
        pop();
        check_window("R5 empty after retire");
        push(fb);
        check_window("R3 ext");
        pop();

        // R6: retire on an empty queue does nothing
        wr(A_FLAG, 32'h20);
        check_flags("R6 empty write");
        push(fa);
        check_flags("R6 one entry");
        pop();
        check_flags("R6 drained");

        // R7 R8 R5: fill, overflow, warning, order
        for (int i = 0; i < DEPTH; i++) push(rand_frame());
        check_flags("R7 full warn");
        push(rand_frame());
        check_flags("R8 overflow set");
        check_window("R8 oldest kept");
        wr(A_FLAG, 32'h80);
        ovf_m = 1'b0;
        check_flags("R8 overflow cleared");
        pop();
        check_flags("R7 five occupied");
        pop();
        check_flags("R7 four occupied");
        wr(A_FLAG, 32'h40);
        check_flags("R7 write ignored");
        drain("R5 order");

        // R11: arrival and retire together on a full queue
        for (int i = 0; i < DEPTH; i++) push(rand_frame());
        fa = rand_frame();
        drive_frame(fa);
        frm_valid = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_FLAG; bus_wdata = 32'h20;
        @(negedge clk);
        frm_valid = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        void'(model_q.pop_front());
        model_q.push_back(fa);
        check_flags("R11 no overflow");
        drain("R11 order");

        // R9: frozen window
        fa = rand_frame();
        fb = rand_frame();
        push(fa);
        push(fb);
        rd(A_CTL, d); chk("R9 first ctl", d, exp_ctl(fa));
        pop();
        push(rand_frame());
        rd(A_IDW, d); chk("R9 frozen id", d, exp_idw(fa));
        rd(A_CTL, d); chk("R9 frozen ctl", d, exp_ctl(fa));
        rd(A_DLO, d); chk("R9 frozen data", d, fa.data[63:32]);
        rd(A_TMR, d);
        rd(A_IDW, d); chk("R9 released id", d, exp_idw(fb));
        check_window("R9 released");
        drain("R9");

        // R10: timer
        rd(A_TMR, t0);
        repeat (7) @(negedge clk);
        rd(A_TMR, t1);
        chk("R10 step", {16'b0, 16'(t1[15:0] - t0[15:0])}, 32'd8);
        chk("R10 upper", {16'b0, t1[31:16]}, 32'd0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            case ($urandom % 6)
                0, 1: push(rand_frame());
                2: pop();
                3: check_window("R5 random");
                4: check_flags("R6 R7 R8 random");
                default: begin
                    wr(A_FLAG, 32'h80);
                    ovf_m = 1'b0;
                end
            endcase
        end
        drain("R5 final");
        check_flags("R6 final");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule